// File: doc/BRIEF.md
# Transfer Controller Activation and Stop Control Registers

This block is the small register slice that sits between a CPU register port and a data transfer engine. It holds two things. The first is a software activation register: a 7-bit vector number plus an enable bit. The vector number is turned into a vector-table address, and the enable bit launches a software-started transfer. The second is a 16-bit module stop register. One bit of it halts the transfer engine.

When the enable bit goes from 0 to 1, the block sends a one-cycle request pulse to the engine, together with the computed address. As each software-started transfer ends, the engine reports two things: the interrupt-disable selection in force, and whether the programmed transfer count ran out. From these the block decides whether the enable bit clears itself or stays set. The stop bit cannot be set while the engine is busy. Once the stop bit is set, stop mode is entered only at a bus-cycle boundary, or at once if the engine is idle. A hardware standby input puts the stop register back to its reset value and leaves the activation register alone.

Top module: `xfer_ctl_regs`

## Requirements
- R1: After reset, the activation register reads 0x00 (enable clear, vector 0) and the stop register reads 0x3FFF. `mod_stop` and `sw_req` are 0, and `vec_addr` is 0x0400.
- R2: `vec_addr` equals 0x0400 + (vector << 1), where the vector is bits 6..0 of the activation register. For example, vector 0x10 gives 0x0420 and vector 0x7F gives 0x04FE. `vec_addr` updates in the cycle after the write that changes the vector.
- R3: A write to the activation register (`reg_addr` 0) with data bit 7 = 1 while the enable bit is 0 gives `sw_req` = 1 for exactly one cycle, in the cycle after the write. The new address is on `vec_addr` in that same cycle. No pulse follows if the enable bit was already 1.
- R4: A transfer end (`xfer_done` with `sw_xfer`) with `intr_dis_sel` = 0 and `count_done` = 0 clears the enable bit. While the software-started transfer is still running, the enable bit stays 1.
- R5: A transfer end with `intr_dis_sel` = 1 leaves the enable bit at 1.
- R6: A transfer end with `count_done` = 1 leaves the enable bit at 1.
- R7: If an automatic clear and a CPU write to the activation register fall in the same cycle, the enable bit ends up 0 and no `sw_req` is raised. The written vector bits still take effect.
- R8: The stop register is read and written a byte at a time: `reg_addr` 1 is bits 15..8 and `reg_addr` 2 is bits 7..0. All 16 bits are read/write.
- R9: A one-cycle `hw_standby` puts the stop register back to 0x3FFF and clears `mod_stop`. It leaves the activation register unchanged.
- R10: While `xfer_busy` = 1, a write that would set bit 14 of the stop register from 0 to 1 leaves bit 14 at 0. The other bits of the same byte are still written. Writing 0 to bit 14 while busy is accepted.
- R11: With bit 14 = 1, `mod_stop` rises in the cycle after a cycle in which `bus_cycle_end` = 1 or `xfer_busy` = 0. Until then it stays 0. Once bit 14 is written to 0, `mod_stop` falls one cycle after the register changes. `eng_halt` shows bit 14.
- R12: `reg_rdata` returns the register chosen by `reg_addr` one cycle after the address is presented, and reading has no side effects. `reg_addr` 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_standby | input | 1 | Hardware standby; reinitialises the stop register |
| reg_addr | input | 2 | Register select: 0 activation, 1 stop high byte, 2 stop low byte |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| xfer_busy | input | 1 | Transfer engine is running a transfer |
| sw_xfer | input | 1 | Current transfer was software-started |
| xfer_done | input | 1 | Transfer end pulse |
| intr_dis_sel | input | 1 | Interrupt-disable selection for the ending transfer |
| count_done | input | 1 | Programmed transfer count exhausted |
| bus_cycle_end | input | 1 | Current engine bus cycle ends this cycle |
| sw_req | output | 1 | One-cycle software activation request |
| vec_addr | output | 16 | Vector-table address |
| eng_halt | output | 1 | Stop bit 14, tells the engine to halt |
| mod_stop | output | 1 | Engine is in module stop mode |

## Verification
The hardest state to reach is a stop bit that is already 1 while the engine is busy and in the middle of a bus cycle. This is the only window in which `mod_stop` must wait. A stop write is refused while busy, and an idle engine enters stop at once. So the bench writes bit 14 in an idle cycle and raises `xfer_busy` in the very next cycle, with `bus_cycle_end` held low. It then holds that state for several cycles before it pulses the bus-cycle boundary. A second hard case is an automatic clear and a CPU enable write landing in the same cycle. The bench drives both strobes on one edge and then reads the register back.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;
  typedef enum logic [1:0] {
    SEL_ACT     = 2'd0,
    SEL_STOP_HI = 2'd1,
    SEL_STOP_LO = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int          BYTE_W   = 8;
  localparam int          STOP_W   = 16;
  localparam int          STOP_IDX = 14;
  localparam logic [15:0] STOP_RST = 16'h3FFF;
endpackage

// File: rtl/xfer_act_reg.sv
module xfer_act_reg #(
  parameter int               VEC_W    = 7,
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_act,
  input  logic [VEC_W:0]    wr_data,
  input  logic              xfer_done,
  input  logic              sw_xfer,
  input  logic              intr_dis_sel,
  input  logic              count_done,
  output logic              act_en,
  output logic [VEC_W-1:0]  act_vec,
  output logic              sw_req,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int PAD_W = ADDR_W - VEC_W - 1;

  logic             auto_clr;
  logic             en_nxt;
  logic [VEC_W-1:0] vec_nxt;

  // Clear only when a software-started transfer ends in the clearing state.
  assign auto_clr = xfer_done & sw_xfer & ~intr_dis_sel & ~count_done;

  always_comb begin
    en_nxt  = act_en;
    vec_nxt = act_vec;
    if (wr_act) begin
      en_nxt  = wr_data[VEC_W];
      vec_nxt = wr_data[VEC_W-1:0];
    end
    if (auto_clr) en_nxt = 1'b0;   // completion beats a concurrent write
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en   <= 1'b0;
      act_vec  <= '0;
      sw_req   <= 1'b0;
      vec_addr <= VEC_BASE;
    end else begin
      act_en   <= en_nxt;
      act_vec  <= vec_nxt;
      sw_req   <= en_nxt & ~act_en;
      vec_addr <= VEC_BASE + {{PAD_W{1'b0}}, vec_nxt, 1'b0};
    end
  end
endmodule

// File: rtl/xfer_stop_reg.sv
module xfer_stop_reg
  import xfer_ctl_pkg::*;
#(
  parameter int          REG_W   = STOP_W,
  parameter int          HALT_IX = STOP_IDX,
  parameter logic [15:0] RST_VAL = STOP_RST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_standby,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic             xfer_busy,
  input  logic             bus_cycle_end,
  output logic [REG_W-1:0] stop_q,
  output logic             mod_stop
);
  localparam int NLANE = REG_W / BYTE_W;

  logic [REG_W-1:0] lane_new;
  logic [NLANE-1:0] lane_we;
  logic [REG_W-1:0] stop_nxt;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign lane_we[b] = (b == 0) ? wr_lo : wr_hi;
    assign lane_new[b*BYTE_W +: BYTE_W] =
      lane_we[b] ? wr_data : stop_q[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    stop_nxt = lane_new;
    // Setting the halt bit is refused while the engine is running.
    if (xfer_busy && !stop_q[HALT_IX]) stop_nxt[HALT_IX] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || hw_standby) begin
      stop_q   <= RST_VAL[REG_W-1:0];
      mod_stop <= 1'b0;
    end else begin
      stop_q   <= stop_nxt;
      mod_stop <= stop_q[HALT_IX] & (mod_stop | bus_cycle_end | ~xfer_busy);
    end
  end
endmodule

// File: rtl/xfer_rd_mux.sv
module xfer_rd_mux
  import xfer_ctl_pkg::*;
#(
  parameter int REG_W = STOP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rd_sel,
  input  logic [BYTE_W-1:0] act_byte,
  input  logic [REG_W-1:0]  stop_q,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] rd_nxt;

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_ACT:     rd_nxt = act_byte;
      SEL_STOP_HI: rd_nxt = stop_q[2*BYTE_W-1:BYTE_W];
      SEL_STOP_LO: rd_nxt = stop_q[BYTE_W-1:0];
      default:     rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/xfer_ctl_regs.sv
module xfer_ctl_regs
  import xfer_ctl_pkg::*;
#(
  parameter int                VEC_W    = 7,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_standby,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              xfer_busy,
  input  logic              sw_xfer,
  input  logic              xfer_done,
  input  logic              intr_dis_sel,
  input  logic              count_done,
  input  logic              bus_cycle_end,
  output logic              sw_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              eng_halt,
  output logic              mod_stop
);
  logic             act_en;
  logic [VEC_W-1:0] act_vec;
  logic [STOP_W-1:0] stop_q;
  logic             wr_act, wr_hi, wr_lo;

  assign wr_act = reg_wr && (reg_addr == SEL_ACT);
  assign wr_hi  = reg_wr && (reg_addr == SEL_STOP_HI);
  assign wr_lo  = reg_wr && (reg_addr == SEL_STOP_LO);

  xfer_act_reg #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_act (
    .clk(clk), .rst(rst), .wr_act(wr_act), .wr_data(reg_wdata[VEC_W:0]),
    .xfer_done(xfer_done), .sw_xfer(sw_xfer), .intr_dis_sel(intr_dis_sel),
    .count_done(count_done), .act_en(act_en), .act_vec(act_vec),
    .sw_req(sw_req), .vec_addr(vec_addr)
  );

  xfer_stop_reg #(.REG_W(STOP_W), .HALT_IX(STOP_IDX), .RST_VAL(STOP_RST)) u_stop (
    .clk(clk), .rst(rst), .hw_standby(hw_standby), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(reg_wdata), .xfer_busy(xfer_busy), .bus_cycle_end(bus_cycle_end),
    .stop_q(stop_q), .mod_stop(mod_stop)
  );

  xfer_rd_mux #(.REG_W(STOP_W)) u_rd (
    .clk(clk), .rst(rst), .rd_sel(reg_addr), .act_byte({act_en, act_vec}),
    .stop_q(stop_q), .rd_data(reg_rdata)
  );

  assign eng_halt = stop_q[STOP_IDX];
endmodule

// File: rtl/xfer_ctl_chk.sv
module xfer_ctl_chk #(
  parameter int                VEC_W    = 7,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0400
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic              xfer_busy,
  input logic              sw_xfer,
  input logic              xfer_done,
  input logic              intr_dis_sel,
  input logic              count_done,
  input logic              bus_cycle_end,
  input logic              sw_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              stop_bit,
  input logic              mod_stop,
  input logic              act_en,
  input logic [VEC_W-1:0]  act_vec
);
  localparam int PAD_W = ADDR_W - VEC_W - 1;
  logic act_wr;
  assign act_wr = reg_wr && (reg_addr == 2'd0);

  p_reset_r1: assert property (@(posedge clk) rst |=> (!sw_req && !mod_stop && !act_en));
  p_vec_map_r2: assert property (@(posedge clk) disable iff (rst)
    vec_addr == VEC_BASE + {{PAD_W{1'b0}}, act_vec, 1'b0});
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst) sw_req |=> !sw_req);
  p_req_edge_r3: assert property (@(posedge clk) disable iff (rst)
    sw_req |-> (act_en && !$past(act_en)));
  p_auto_clear_r4_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && sw_xfer && !intr_dis_sel && !count_done) |=> (!act_en && !sw_req));
  p_hold_dis_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && sw_xfer && intr_dis_sel && act_en && !act_wr) |=> act_en);
  p_hold_cnt_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && sw_xfer && count_done && act_en && !act_wr) |=> act_en);
  p_stop_guard_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && !stop_bit) |=> !stop_bit);
  p_stop_wait_r11: assert property (@(posedge clk) disable iff (rst)
    (!mod_stop && xfer_busy && !bus_cycle_end) |=> !mod_stop);
  p_stop_exit_r11: assert property (@(posedge clk) disable iff (rst)
    !stop_bit |=> !mod_stop);
endmodule

bind xfer_ctl_regs xfer_ctl_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .xfer_busy(xfer_busy),
  .sw_xfer(sw_xfer), .xfer_done(xfer_done), .intr_dis_sel(intr_dis_sel),
  .count_done(count_done), .bus_cycle_end(bus_cycle_end), .sw_req(sw_req),
  .vec_addr(vec_addr), .stop_bit(eng_halt), .mod_stop(mod_stop),
  .act_en(act_en), .act_vec(act_vec)
);

// File: tb/xfer_ctl_regs_bench.sv
`timescale 1ns/1ps
module xfer_ctl_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_standby = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic xfer_busy = 1'b0, sw_xfer = 1'b0, xfer_done = 1'b0;
  logic intr_dis_sel = 1'b0, count_done = 1'b0, bus_cycle_end = 1'b0;
  logic sw_req, eng_halt, mod_stop;
  logic [15:0] vec_addr;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xfer_ctl_regs u_xfer_ctl_regs (
    .clk(clk), .rst(rst), .hw_standby(hw_standby), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_busy(xfer_busy), .sw_xfer(sw_xfer), .xfer_done(xfer_done),
    .intr_dis_sel(intr_dis_sel), .count_done(count_done),
    .bus_cycle_end(bus_cycle_end), .sw_req(sw_req), .vec_addr(vec_addr),
    .eng_halt(eng_halt), .mod_stop(mod_stop)
  );

  // {vector, expected address}
  localparam logic [22:0] VTAB [0:5] = '{
    {7'h10, 16'h0420}, {7'h00, 16'h0400}, {7'h7F, 16'h04FE},
    {7'h01, 16'h0402}, {7'h55, 16'h04AA}, {7'h2A, 16'h0454}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_wr = 1'b0;
    step();
    d = reg_rdata;
  endtask

  task automatic done_pulse(input logic dis, input logic cnt);
    sw_xfer = 1'b1; xfer_done = 1'b1; intr_dis_sel = dis; count_done = cnt;
    step();
    xfer_done = 1'b0; sw_xfer = 1'b0; intr_dis_sel = 1'b0; count_done = 1'b0;
  endtask

  initial begin
    logic [7:0] d, d2;
    step(); step();
    rst = 1'b0;
    step();

    // R1 reset state
    check("R1 sw_req", sw_req, 0);
    check("R1 mod_stop", mod_stop, 0);
    check("R1 vec_addr", vec_addr, 16'h0400);
    rd(2'd0, d); check("R1 act", d, 8'h00);
    rd(2'd1, d); check("R1 stop hi", d, 8'h3F);
    rd(2'd2, d); check("R1 stop lo", d, 8'h FF);

    // Table walk: R2 address map, R3 pulse, R4 auto clear
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, {1'b1, VTAB[i][22:16]});
      check("R3 sw_req pulse", sw_req, 1);
      check("R2 vec_addr", vec_addr, VTAB[i][15:0]);
      step();
      check("R3 sw_req one cycle", sw_req, 0);
      done_pulse(1'b0, 1'b0);
      rd(2'd0, d); check("R4 enable cleared", d, {1'b0, VTAB[i][22:16]});
    end

    // R3: no pulse if already enabled
    wr(2'd0, 8'h85);
    check("R3 first pulse", sw_req, 1);
    step();
    wr(2'd0, 8'h86);
    check("R3 no pulse when enabled", sw_req, 0);
    check("R2 vec_addr follows", vec_addr, 16'h040C);

    // R5 and R6 holding
    done_pulse(1'b1, 1'b0);
    rd(2'd0, d); check("R5 dis_sel holds", d, 8'h86);
    done_pulse(1'b0, 1'b1);
    rd(2'd0, d); check("R6 count holds", d, 8'h86);

    // R4 in progress: stays set while running
    sw_xfer = 1'b1; xfer_busy = 1'b1;
    step(); step(); step();
    rd(2'd0, d); check("R4 hold in progress", d, 8'h86);
    xfer_busy = 1'b0;
    done_pulse(1'b0, 1'b0);
    rd(2'd0, d); check("R4 clear at end", d, 8'h06);

    // R7 collision: enable write and auto clear together, enable was 0
    reg_addr = 2'd0; reg_wdata = 8'h93; reg_wr = 1'b1;
    sw_xfer = 1'b1; xfer_done = 1'b1;
    step();
    reg_wr = 1'b0; sw_xfer = 1'b0; xfer_done = 1'b0;
    check("R7 no pulse", sw_req, 0);
    rd(2'd0, d); check("R7 clear wins", d, 8'h13);
    // R7 collision with enable already 1
    wr(2'd0, 8'h81);
    step();
    reg_addr = 2'd0; reg_wdata = 8'h9A; reg_wr = 1'b1;
    sw_xfer = 1'b1; xfer_done = 1'b1;
    step();
    reg_wr = 1'b0; sw_xfer = 1'b0; xfer_done = 1'b0;
    rd(2'd0, d); check("R7 clear wins set", d, 8'h1A);

    // R8 byte-wide stop register
    wr(2'd1, 8'h12); wr(2'd2, 8'hA5);
    rd(2'd1, d); check("R8 hi", d, 8'h12);
    rd(2'd2, d); check("R8 lo", d, 8'hA5);

    // R10 guard while busy
    xfer_busy = 1'b1;
    wr(2'd1, 8'h7F);
    rd(2'd1, d); check("R10 set refused", d, 8'h3F);
    check("R10 eng_halt", eng_halt, 0);
    xfer_busy = 1'b0;
    wr(2'd1, 8'h40);
    xfer_busy = 1'b1;
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R10 clear accepted", d, 8'h00);
    xfer_busy = 1'b0;
    step();

    // R11 stop waits for bus cycle end
    wr(2'd1, 8'h40);
    xfer_busy = 1'b1; bus_cycle_end = 1'b0;
    step();
    check("R11 eng_halt", eng_halt, 1);
    check("R11 wait 1", mod_stop, 0);
    step(); step();
    check("R11 wait 3", mod_stop, 0);
    bus_cycle_end = 1'b1;
    step();
    bus_cycle_end = 1'b0;
    check("R11 enter", mod_stop, 1);
    xfer_busy = 1'b0;
    wr(2'd1, 8'h00);
    check("R11 still set", mod_stop, 1);
    step();
    check("R11 exit", mod_stop, 0);

    // R9 hardware standby
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h81);
    step();
    check("R9 pre stop", mod_stop, 1);
    hw_standby = 1'b1;
    step();
    hw_standby = 1'b0;
    check("R9 mod_stop cleared", mod_stop, 0);
    rd(2'd1, d); check("R9 hi reinit", d, 8'h3F);
    rd(2'd2, d); check("R9 lo reinit", d, 8'hFF);
    rd(2'd0, d); check("R9 act kept", d, 8'h81);

    // R12 reads have no side effects
    rd(2'd0, d); rd(2'd0, d2);
    check("R12 repeat read", d2, d);
    check("R12 no request", sw_req, 0);
    rd(2'd3, d); check("R12 unused reads 0", d, 8'h00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule